// File: doc/BRIEF.md
# Instruction Fetch Line Controller

This block feeds a processor front end one cache line at a time. It keeps the fetch program counter and one buffered 64-byte line. When the counter leaves that line, it sends a line read to memory at the counter with its low six bits cleared. If memory refuses the read, it waits for a retry. It then waits for the matching response. With a valid line in hand, it hands up to `FETCH_W` consecutive 32-bit instruction words per cycle to a downstream buffer.

The number of words handed over each cycle is limited by the free space downstream, the words left in the line, the free rename registers, and the first slot flagged as predicted taken. A status code on `state_o` shows why fetch is stalled. Redirects from the back end squash the line. A response that arrives after a squash is recognised by its tag, then counted and discarded. A fault on a fetch parks the block in a trap state, behind a single fault-carrying no-op.

Top module: `ifetch_line_ctrl`

## Requirements
- R1: After reset `state_o` is 0 (running), both counters are 0, the line is invalid, and the first cycle presents a read for `RESET_PC` with its low 6 bits cleared.
- R2: A line read is presented in the running state whenever the line is invalid or the PC lies outside [base, base+64). The read carries the address PC with bits 5:0 cleared and a fresh tag on `req_id_o`.
- R3: If `req_ready_i` is low when a read is presented, the state becomes 1 (retry-wait). In that state the read is presented again only in cycles with `retry_i` high, with an unchanged address and tag. A retry with `req_ready_i` high moves the state to 2 (response-wait).
- R4: A response is taken only in state 2 when `rsp_id_i` equals the outstanding tag. Every other cycle with `rsp_valid_i` high adds 1 to `drop_cnt_o` and leaves the line unchanged.
- R5: When a response is taken, the line becomes valid. The next state is 0, or 3 (rename-blocked) if `free_regs_i`, read as two's complement, is zero or negative.
- R6: Slot k carries the word at line byte offset 4*(PC[5:2]+k), taken little-endian from `rsp_data_i`, where byte i is bits 8i+7:8i. Its PC is PC+4k. The valid slots always run from slot 0 upward.
- R7: In the running state with a hit, the slot count is the minimum of `FETCH_W`, `buf_space_i`, the words left in the line, and `free_regs_i`. The list is cut after the first slot whose `pred_taken_i` bit is set. The next PC is `pred_target_i` after such a cut, and PC+4*count otherwise.
- R8: If the slot count equals `free_regs_i`, is nonzero, and no taken cut happened, the state becomes 3. State 3 emits nothing and returns to 0 once `free_regs_i` is positive.
- R9: If `be_block_i` is high in a cycle that emits (and R8 does not apply), the state becomes 4 (back-end-blocked). It returns to 0 in the cycle after `be_block_i` is seen low.
- R10: When a read would be presented but `fault_i` is high, no read is sent. Slot 0 carries `NOP_WORD` at the PC with `out_fault_o` high, and the state becomes 5 (trap-pending), where it stays until a redirect.
- R11: `redirect_i` loads `redirect_pc_i`, sets state 0, invalidates the line, and suppresses emission that cycle. A response for any read issued before it is dropped.
- R12: In every state other than 0, no slot is valid, and `stall_cnt_o` increases by 1 each cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| redirect_i | input | 1 | Squash and redirect fetch |
| redirect_pc_i | input | ADDR_W | New fetch PC |
| req_valid_o | output | 1 | Line read presented |
| req_addr_o | output | ADDR_W | Line-aligned read address |
| req_id_o | output | ID_W | Read tag |
| req_ready_i | input | 1 | Memory accepts the presented read |
| retry_i | input | 1 | Memory invites a refused read again |
| fault_i | input | 1 | Fault on the read that would be presented |
| rsp_valid_i | input | 1 | Line response valid |
| rsp_id_i | input | ID_W | Response tag |
| rsp_data_i | input | LINE_BYTES*8 | Line bytes, byte i at bits 8i+7:8i |
| free_regs_i | input | FREG_W | Free rename registers, two's complement |
| be_block_i | input | 1 | Back end cannot take instructions |
| buf_space_i | input | SPACE_W | Free downstream buffer entries |
| pred_taken_i | input | FETCH_W | Per-slot predicted-taken flags |
| pred_target_i | input | ADDR_W | Target of the first taken slot |
| out_valid_o | output | FETCH_W | Slot valid bits |
| out_inst_o | output | FETCH_W*INST_W | Slot instruction words |
| out_pc_o | output | FETCH_W*ADDR_W | Slot PCs |
| out_fault_o | output | 1 | Slot 0 is a fault-carrying no-op |
| state_o | output | 3 | 0 run, 1 retry-wait, 2 response-wait, 3 rename-blocked, 4 back-end-blocked, 5 trap |
| stall_cnt_o | output | CNT_W | Cycles spent outside the running state |
| drop_cnt_o | output | CNT_W | Discarded responses |

## Verification
The hardest case to reach is a response that is stale but well formed: a reply whose tag belonged to a read that a redirect cancelled, arriving after a new PC is already loaded. The bench issues a read, lets it be accepted, then redirects before answering. It then drives the old tag back and checks that the drop counter moves while the fault no-op of the new PC is emitted in the same cycle. The retry path needs memory to refuse and then invite again with and without acceptance. This is driven directly through `req_ready_i` and `retry_i`. A sweep over word offset, buffer space, free registers and taken-slot position refills a line for every combination and checks the slot count, every slot word and PC, and the state that follows.

// File: rtl/ifl_pkg.sv
package ifl_pkg;
  typedef enum logic [2:0] {
    ST_RUN     = 3'd0,
    ST_RETRY   = 3'd1,
    ST_RESP    = 3'd2,
    ST_REN_BLK = 3'd3,
    ST_BE_BLK  = 3'd4,
    ST_TRAP    = 3'd5
  } ifl_state_e;
endpackage

// File: rtl/ifl_line_buf.sv
module ifl_line_buf #(
  parameter int LINE_N_W   = 26,
  parameter int INST_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int FETCH_W    = 4
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [LINE_N_W-1:0]         line_i,
  input  logic [$clog2(LINE_BYTES*8/INST_W)-1:0] widx_i,
  input  logic                        open_i,
  input  logic                        inval_i,
  input  logic                        fill_i,
  input  logic [LINE_BYTES*8-1:0]     fill_data_i,
  output logic                        hit_o,
  output logic [FETCH_W*INST_W-1:0]   slot_word_o
);
  localparam int WORDS = LINE_BYTES * 8 / INST_W;
  localparam int WI_W  = $clog2(WORDS);

  logic [LINE_N_W-1:0]          base_q;
  logic                         valid_q;
  logic [WORDS-1:0][INST_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      if (inval_i || open_i) valid_q <= 1'b0;
      else if (fill_i)       valid_q <= 1'b1;
      if (open_i) base_q <= line_i;
    end
  end

  always_ff @(posedge clk_i) begin
    if (fill_i) data_q <= fill_data_i;
  end

  assign hit_o = valid_q && (line_i == base_q);

  for (genvar k = 0; k < FETCH_W; k++) begin : g_slot
    logic [WI_W-1:0] idx;
    assign idx = widx_i + WI_W'(k);
    assign slot_word_o[k*INST_W +: INST_W] = data_q[idx];
  end
endmodule

// File: rtl/ifl_slot_sel.sv
module ifl_slot_sel #(
  parameter int FETCH_W = 4,
  parameter int WORDS   = 16,
  parameter int SPACE_W = 4,
  parameter int FREG_W  = 8,
  parameter int CNT_W   = 3
) (
  input  logic                     en_i,
  input  logic [$clog2(WORDS)-1:0] widx_i,
  input  logic [SPACE_W-1:0]       space_i,
  input  logic [FREG_W-1:0]        free_regs_i,
  input  logic [FETCH_W-1:0]       taken_i,
  output logic [FETCH_W-1:0]       vld_o,
  output logic [CNT_W-1:0]         n_o,
  output logic                     taken_stop_o,
  output logic                     regs_out_o
);
  int   cnt_c;
  logic go_c;

  // free_regs_i is only consulted while en_i, which implies it is positive
  always_comb begin
    cnt_c        = 0;
    go_c         = en_i;
    taken_stop_o = 1'b0;
    vld_o        = '0;
    for (int k = 0; k < FETCH_W; k++) begin
      if (go_c && k < int'(space_i) && (int'(widx_i) + k) < WORDS &&
          k < int'(free_regs_i)) begin
        vld_o[k] = 1'b1;
        cnt_c    = cnt_c + 1;
        if (taken_i[k]) begin
          taken_stop_o = 1'b1;
          go_c         = 1'b0;
        end
      end else begin
        go_c = 1'b0;
      end
    end
    n_o        = CNT_W'(cnt_c);
    regs_out_o = en_i && !taken_stop_o && cnt_c > 0 && cnt_c == int'(free_regs_i);
  end
endmodule

// File: rtl/ifl_fsm.sv
module ifl_fsm
  import ifl_pkg::*;
#(
  parameter int          ADDR_W   = 32,
  parameter int          ID_W     = 4,
  parameter int          FREG_W   = 8,
  parameter int          CNT_W    = 3,
  parameter int          STALL_W  = 16,
  parameter logic [31:0] RESET_PC = 32'h0000_1000
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               redirect_i,
  input  logic [ADDR_W-1:0]  redirect_pc_i,
  input  logic               hit_i,
  input  logic               fault_i,
  input  logic               req_ready_i,
  input  logic               retry_i,
  input  logic               rsp_valid_i,
  input  logic [ID_W-1:0]    rsp_id_i,
  input  logic [FREG_W-1:0]  free_regs_i,
  input  logic               be_block_i,
  input  logic [CNT_W-1:0]   n_i,
  input  logic               taken_stop_i,
  input  logic               regs_out_i,
  input  logic [ADDR_W-1:0]  pred_target_i,
  output logic [2:0]         state_o,
  output logic [ADDR_W-1:0]  pc_o,
  output logic               req_valid_o,
  output logic [ID_W-1:0]    req_id_o,
  output logic               open_o,
  output logic               inval_o,
  output logic               fill_o,
  output logic               emit_en_o,
  output logic               inject_o,
  output logic [STALL_W-1:0] stall_cnt_o,
  output logic [STALL_W-1:0] drop_cnt_o
);
  ifl_state_e         state_q, state_d;
  logic [ADDR_W-1:0]  pc_q, pc_d;
  logic [ID_W-1:0]    id_q;
  logic [STALL_W-1:0] stall_q, drop_q;
  logic               fr_pos, in_run, miss_run, accept, drop;

  assign fr_pos    = !free_regs_i[FREG_W-1] && (|free_regs_i);
  assign in_run    = !redirect_i && (state_q == ST_RUN);
  assign miss_run  = in_run && !hit_i;
  assign open_o    = miss_run && !fault_i;
  assign inject_o  = miss_run && fault_i;
  assign emit_en_o = in_run && hit_i && fr_pos;
  assign inval_o   = redirect_i;
  assign accept    = !redirect_i && (state_q == ST_RESP) && rsp_valid_i && (rsp_id_i == id_q);
  assign drop      = rsp_valid_i && !accept;
  assign fill_o    = accept;

  assign req_valid_o = open_o || (!redirect_i && state_q == ST_RETRY && retry_i);
  assign req_id_o    = (state_q == ST_RUN) ? id_q + ID_W'(1) : id_q;

  always_comb begin
    state_d = state_q;
    pc_d    = pc_q;
    if (redirect_i) begin
      state_d = ST_RUN;
      pc_d    = redirect_pc_i;
    end else begin
      unique case (state_q)
        ST_RUN: begin
          if (!hit_i) begin
            if (fault_i)          state_d = ST_TRAP;
            else if (req_ready_i) state_d = ST_RESP;
            else                  state_d = ST_RETRY;
          end else if (!fr_pos) begin
            state_d = ST_REN_BLK;
          end else begin
            pc_d = taken_stop_i ? pred_target_i : pc_q + ADDR_W'({n_i, 2'b00});
            if (regs_out_i)      state_d = ST_REN_BLK;
            else if (be_block_i) state_d = ST_BE_BLK;
          end
        end
        ST_RETRY:   if (retry_i && req_ready_i) state_d = ST_RESP;
        ST_RESP:    if (accept) state_d = fr_pos ? ST_RUN : ST_REN_BLK;
        ST_REN_BLK: if (fr_pos) state_d = ST_RUN;
        ST_BE_BLK:  if (!be_block_i) state_d = ST_RUN;
        ST_TRAP:    state_d = ST_TRAP;
        default:    state_d = ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RUN;
      pc_q    <= ADDR_W'(RESET_PC);
      id_q    <= '0;
      stall_q <= '0;
      drop_q  <= '0;
    end else begin
      state_q <= state_d;
      pc_q    <= pc_d;
      if (open_o)            id_q    <= id_q + ID_W'(1);
      if (state_q != ST_RUN) stall_q <= stall_q + STALL_W'(1);
      if (drop)              drop_q  <= drop_q + STALL_W'(1);
    end
  end

  assign state_o     = state_q;
  assign pc_o        = pc_q;
  assign stall_cnt_o = stall_q;
  assign drop_cnt_o  = drop_q;
endmodule

// File: rtl/ifetch_line_ctrl.sv
module ifetch_line_ctrl #(
  parameter int          ADDR_W     = 32,
  parameter int          INST_W     = 32,
  parameter int          LINE_BYTES = 64,
  parameter int          FETCH_W    = 4,
  parameter int          ID_W       = 4,
  parameter int          FREG_W     = 8,
  parameter int          SPACE_W    = 4,
  parameter int          CNT_W      = 16,
  parameter logic [31:0] RESET_PC   = 32'h0000_1000,
  parameter logic [31:0] NOP_WORD   = 32'h0000_0013
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      redirect_i,
  input  logic [ADDR_W-1:0]         redirect_pc_i,
  output logic                      req_valid_o,
  output logic [ADDR_W-1:0]         req_addr_o,
  output logic [ID_W-1:0]           req_id_o,
  input  logic                      req_ready_i,
  input  logic                      retry_i,
  input  logic                      fault_i,
  input  logic                      rsp_valid_i,
  input  logic [ID_W-1:0]           rsp_id_i,
  input  logic [LINE_BYTES*8-1:0]   rsp_data_i,
  input  logic [FREG_W-1:0]         free_regs_i,
  input  logic                      be_block_i,
  input  logic [SPACE_W-1:0]        buf_space_i,
  input  logic [FETCH_W-1:0]        pred_taken_i,
  input  logic [ADDR_W-1:0]         pred_target_i,
  output logic [FETCH_W-1:0]        out_valid_o,
  output logic [FETCH_W*INST_W-1:0] out_inst_o,
  output logic [FETCH_W*ADDR_W-1:0] out_pc_o,
  output logic                      out_fault_o,
  output logic [2:0]                state_o,
  output logic [CNT_W-1:0]          stall_cnt_o,
  output logic [CNT_W-1:0]          drop_cnt_o
);
  localparam int WORD_B   = INST_W / 8;
  localparam int WORDS    = LINE_BYTES / WORD_B;
  localparam int OFF_W    = $clog2(LINE_BYTES);
  localparam int WB_W     = $clog2(WORD_B);
  localparam int WI_W     = $clog2(WORDS);
  localparam int LINE_N_W = ADDR_W - OFF_W;
  localparam int N_W      = $clog2(FETCH_W + 1);

  logic [ADDR_W-1:0]         pc;
  logic                      hit, open, inval, fill, emit_en, inject;
  logic                      taken_stop, regs_out;
  logic [N_W-1:0]            n_emit;
  logic [FETCH_W-1:0]        vld;
  logic [FETCH_W*INST_W-1:0] slot_word;
  logic [WI_W-1:0]           widx;

  assign widx = pc[OFF_W-1:WB_W];

  ifl_fsm #(
    .ADDR_W(ADDR_W), .ID_W(ID_W), .FREG_W(FREG_W), .CNT_W(N_W),
    .STALL_W(CNT_W), .RESET_PC(RESET_PC)
  ) u_fsm (
    .clk_i, .rst_ni, .redirect_i, .redirect_pc_i,
    .hit_i(hit), .fault_i, .req_ready_i, .retry_i,
    .rsp_valid_i, .rsp_id_i, .free_regs_i, .be_block_i,
    .n_i(n_emit), .taken_stop_i(taken_stop), .regs_out_i(regs_out),
    .pred_target_i, .state_o, .pc_o(pc), .req_valid_o, .req_id_o,
    .open_o(open), .inval_o(inval), .fill_o(fill), .emit_en_o(emit_en),
    .inject_o(inject), .stall_cnt_o, .drop_cnt_o
  );

  ifl_line_buf #(
    .LINE_N_W(LINE_N_W), .INST_W(INST_W), .LINE_BYTES(LINE_BYTES), .FETCH_W(FETCH_W)
  ) u_line (
    .clk_i, .rst_ni, .line_i(pc[ADDR_W-1:OFF_W]), .widx_i(widx),
    .open_i(open), .inval_i(inval), .fill_i(fill), .fill_data_i(rsp_data_i),
    .hit_o(hit), .slot_word_o(slot_word)
  );

  ifl_slot_sel #(
    .FETCH_W(FETCH_W), .WORDS(WORDS), .SPACE_W(SPACE_W), .FREG_W(FREG_W), .CNT_W(N_W)
  ) u_sel (
    .en_i(emit_en), .widx_i(widx), .space_i(buf_space_i), .free_regs_i,
    .taken_i(pred_taken_i), .vld_o(vld), .n_o(n_emit),
    .taken_stop_o(taken_stop), .regs_out_o(regs_out)
  );

  assign req_addr_o  = {pc[ADDR_W-1:OFF_W], OFF_W'(0)};
  assign out_valid_o = inject ? FETCH_W'(1) : vld;
  assign out_fault_o = inject;

  for (genvar k = 0; k < FETCH_W; k++) begin : g_out
    assign out_pc_o[k*ADDR_W +: ADDR_W] = pc + ADDR_W'(k * WORD_B);
    if (k == 0) begin : g_first
      assign out_inst_o[INST_W-1:0] = inject ? INST_W'(NOP_WORD) : slot_word[INST_W-1:0];
    end else begin : g_rest
      assign out_inst_o[k*INST_W +: INST_W] = slot_word[k*INST_W +: INST_W];
    end
  end
endmodule

// File: rtl/ifl_checker.sv
module ifl_checker
  import ifl_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int FETCH_W    = 4,
  parameter int CNT_W      = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               redirect_i,
  input logic               retry_i,
  input logic               req_ready_i,
  input logic               req_valid_o,
  input logic [ADDR_W-1:0]  req_addr_o,
  input logic [FETCH_W-1:0] out_valid_o,
  input logic [2:0]         state_o,
  input logic [CNT_W-1:0]   stall_cnt_o
);
  localparam int OFF_W = $clog2(LINE_BYTES);

  AST_REQ_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> req_addr_o[OFF_W-1:0] == '0); // R2

  AST_RETRY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_RETRY && !redirect_i && !(retry_i && req_ready_i))
      |=> (state_o == ST_RETRY && $stable(req_addr_o))); // R3

  AST_RETRY_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_RETRY && !retry_i) |-> !req_valid_o); // R3

  AST_SLOTS_CONTIG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o & (out_valid_o + FETCH_W'(1))) == '0); // R6

  AST_TRAP_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_TRAP && !redirect_i) |=> state_o == ST_TRAP); // R10

  AST_REDIRECT_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_i |=> state_o == ST_RUN); // R11

  AST_NO_EMIT_STALLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o != ST_RUN) |-> out_valid_o == '0); // R12

  AST_STALL_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o != ST_RUN) |=> stall_cnt_o == $past(stall_cnt_o) + CNT_W'(1)); // R12
endmodule

bind ifetch_line_ctrl ifl_checker #(
  .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .FETCH_W(FETCH_W), .CNT_W(CNT_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .redirect_i(redirect_i), .retry_i(retry_i),
  .req_ready_i(req_ready_i), .req_valid_o(req_valid_o), .req_addr_o(req_addr_o),
  .out_valid_o(out_valid_o), .state_o(state_o), .stall_cnt_o(stall_cnt_o)
);

// File: tb/sim_ifetch_line_ctrl.sv
`timescale 1ns/1ps
module sim_ifetch_line_ctrl;
  localparam int A = 32, FW = 4, IW = 4, LB = 64;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic            redirect, req_valid, req_ready, retry, fault, rsp_valid, be_block, out_fault;
  logic [A-1:0]    redirect_pc, req_addr, pred_target;
  logic [IW-1:0]   req_id, rsp_id;
  logic [LB*8-1:0] rsp_data;
  logic [7:0]      free_regs;
  logic [3:0]      buf_space;
  logic [FW-1:0]   pred_taken, out_valid;
  logic [FW*32-1:0] out_inst;
  logic [FW*A-1:0] out_pc;
  logic [2:0]      state;
  logic [15:0]     stall_cnt, drop_cnt;

  ifetch_line_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .redirect_i(redirect), .redirect_pc_i(redirect_pc),
    .req_valid_o(req_valid), .req_addr_o(req_addr), .req_id_o(req_id),
    .req_ready_i(req_ready), .retry_i(retry), .fault_i(fault),
    .rsp_valid_i(rsp_valid), .rsp_id_i(rsp_id), .rsp_data_i(rsp_data),
    .free_regs_i(free_regs), .be_block_i(be_block), .buf_space_i(buf_space),
    .pred_taken_i(pred_taken), .pred_target_i(pred_target),
    .out_valid_o(out_valid), .out_inst_o(out_inst), .out_pc_o(out_pc),
    .out_fault_o(out_fault), .state_o(state), .stall_cnt_o(stall_cnt), .drop_cnt_o(drop_cnt)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_word(input logic [31:0] a);
    return a ^ 32'hA5A5_0000;
  endfunction

  function automatic logic [LB*8-1:0] mk_line(input logic [31:0] base);
    logic [LB*8-1:0] d;
    for (int w = 0; w < LB / 4; w++) d[w*32 +: 32] = mk_word(base + 32'(4 * w));
    return d;
  endfunction

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic idle();
    redirect = 0; retry = 0; fault = 0; rsp_valid = 0; be_block = 0;
    buf_space = 0; pred_taken = '0; req_ready = 1; free_regs = 8'd8;
  endtask

  task automatic fill_at(input logic [31:0] pc, input int fr);
    logic [IW-1:0] id;
    idle(); redirect = 1; redirect_pc = pc; tick();
    idle(); free_regs = 8'(fr); @(negedge clk); id = req_id; tick();
    idle(); free_regs = 8'(fr); rsp_valid = 1; rsp_id = id;
    rsp_data = mk_line({pc[31:6], 6'b0}); tick();
    idle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [IW-1:0] id, id2;
    logic [15:0] s0, d0;
    idle(); redirect_pc = '0; pred_target = '0; rsp_id = '0; rsp_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 state in reset", 64'(state), 0);
    chk("R1 stall in reset", 64'(stall_cnt), 0);
    chk("R1 drop in reset", 64'(drop_cnt), 0);
    chk("R1 no slots in reset", 64'(out_valid), 0);
    @(posedge clk); #1; rst_n = 1;
    @(negedge clk);
    chk("R1 first read", 64'(req_valid), 1);
    chk("R1 first addr", 64'(req_addr), 64'h1000);

    // R2 R3 retry path
    tick(); idle(); redirect = 1; redirect_pc = 32'h1000_0104; tick();
    idle(); req_ready = 0; @(negedge clk);
    chk("R2 read valid", 64'(req_valid), 1);
    chk("R2 read addr", 64'(req_addr), 64'h1000_0100);
    id = req_id; s0 = stall_cnt; tick();
    idle(); @(negedge clk);
    chk("R3 retry state", 64'(state), 1);
    chk("R3 quiet without retry", 64'(req_valid), 0);
    tick();
    idle(); retry = 1; req_ready = 0; @(negedge clk);
    chk("R3 represent on retry", 64'(req_valid), 1);
    chk("R3 same addr", 64'(req_addr), 64'h1000_0100);
    chk("R3 same tag", 64'(req_id), 64'(id));
    chk("R12 stall counts", 64'(stall_cnt), 64'(s0 + 16'd1));
    tick();
    idle(); retry = 1; tick();
    // R4 wrong tag dropped
    idle(); rsp_valid = 1; rsp_id = id + 4'd1; rsp_data = mk_line(32'h1000_0100);
    @(negedge clk); chk("R3 resp-wait", 64'(state), 2); d0 = drop_cnt; tick();
    idle(); rsp_valid = 1; rsp_id = id; free_regs = 0; rsp_data = mk_line(32'h1000_0100);
    @(negedge clk);
    chk("R4 stale counted", 64'(drop_cnt), 64'(d0 + 16'd1));
    chk("R4 still waiting", 64'(state), 2);
    tick();
    // R5 R8 rename-blocked
    idle(); free_regs = 0; buf_space = 4; @(negedge clk);
    chk("R5 rename-blocked", 64'(state), 3);
    chk("R8 no emit", 64'(out_valid), 0);
    tick();
    idle(); free_regs = 8'hFF; buf_space = 4; @(negedge clk);
    chk("R5 negative regs stay", 64'(state), 3); tick();
    idle(); free_regs = 8; buf_space = 4; tick();
    idle(); buf_space = 4; @(negedge clk);
    chk("R8 back to run", 64'(state), 0);
    chk("R6 four slots", 64'(out_valid), 64'hF);
    chk("R6 slot0 pc", 64'(out_pc[31:0]), 64'h1000_0104);
    chk("R6 slot3 inst", 64'(out_inst[127:96]), 64'(mk_word(32'h1000_0110)));
    tick();
    idle(); buf_space = 4; pred_taken = 4'b0010; pred_target = 32'h1000_0130; @(negedge clk);
    chk("R7 sequential next pc", 64'(out_pc[31:0]), 64'h1000_0114);
    chk("R7 taken cut", 64'(out_valid), 64'h3);
    tick();
    idle(); buf_space = 4; be_block = 1; @(negedge clk);
    chk("R7 taken target", 64'(out_pc[31:0]), 64'h1000_0130);
    chk("R7 line tail", 64'(out_valid), 64'hF);
    tick();
    idle(); be_block = 1; buf_space = 4; @(negedge clk);
    chk("R9 back-end-blocked", 64'(state), 4);
    chk("R9 no emit", 64'(out_valid), 0);
    tick();
    idle(); @(negedge clk); chk("R9 one bubble", 64'(state), 4); tick();
    idle(); @(negedge clk);
    chk("R9 run again", 64'(state), 0);
    chk("R2 next line read", 64'(req_valid), 1);
    chk("R2 next line addr", 64'(req_addr), 64'h1000_0140);
    id2 = req_id; tick();
    // R11 redirect cancels, R10 fault
    idle(); redirect = 1; redirect_pc = 32'h1000_0200; tick();
    idle(); fault = 1; rsp_valid = 1; rsp_id = id2; rsp_data = mk_line(32'h1000_0140);
    d0 = drop_cnt; @(negedge clk);
    chk("R10 no read on fault", 64'(req_valid), 0);
    chk("R10 one slot", 64'(out_valid), 1);
    chk("R10 fault flag", 64'(out_fault), 1);
    chk("R10 nop word", 64'(out_inst[31:0]), 64'h13);
    chk("R10 nop pc", 64'(out_pc[31:0]), 64'h1000_0200);
    tick();
    idle(); @(negedge clk);
    chk("R11 cancelled response dropped", 64'(drop_cnt), 64'(d0 + 16'd1));
    chk("R10 trap state", 64'(state), 5);
    tick(); tick();
    idle(); @(negedge clk);
    chk("R10 trap sticky", 64'(state), 5);
    chk("R10 no read in trap", 64'(req_valid), 0);
    tick();
    idle(); redirect = 1; redirect_pc = 32'h1000_0300; tick();
    idle(); @(negedge clk);
    chk("R11 run after redirect", 64'(state), 0);
    chk("R11 line invalidated", 64'(req_addr), 64'h1000_0300);
    tick();

    // R6 R7 R8 sweep
    for (int wi = 0; wi < 16; wi++)
      for (int sp = 0; sp < 6; sp++)
        for (int fr = 1; fr < 6; fr++)
          for (int t = 0; t < 5; t++) begin
            logic [31:0] base, pc;
            int lim, n;
            bit cut;
            base = 32'h0000_2000 + 32'(((wi + sp + fr + t) % 8) * 64);
            pc = base + 32'(4 * wi);
            fill_at(pc, fr);
            lim = FW;
            if (sp < lim) lim = sp;
            if (16 - wi < lim) lim = 16 - wi;
            if (fr < lim) lim = fr;
            cut = (t < FW) && (t < lim);
            n = cut ? t + 1 : lim;
            buf_space = 4'(sp); free_regs = 8'(fr);
            pred_taken = (t < FW) ? 4'(1 << t) : 4'b0;
            @(negedge clk);
            chk("R7 slot count", 64'(out_valid), 64'((1 << n) - 1));
            for (int k = 0; k < n; k++) begin
              chk("R6 slot inst", 64'(out_inst[k*32 +: 32]), 64'(mk_word(pc + 32'(4 * k))));
              chk("R6 slot pc", 64'(out_pc[k*32 +: 32]), 64'(pc + 32'(4 * k)));
            end
            tick();
            idle(); free_regs = 8'(fr); @(negedge clk);
            chk("R8 state after emit", 64'(state), (!cut && n > 0 && n == fr) ? 64'd3 : 64'd0);
            tick();
          end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule